// File: doc/BRIEF.md
# Errored and Unavailable Seconds Monitor

This block keeps performance-monitoring counts for an emulated private line. Once per second a tick arrives together with that second's summary: how many packets were expected, how many were lost, whether the packet-loss or degradation defect was active, and whether any received packet carried the far end's remote-defect flag. From these the block classifies each second as clean, errored or severely errored, for the near end and the far end separately.

Each end has its own unavailability state with hysteresis. A configurable run of consecutive severely errored seconds declares unavailability, and that whole run is then counted as unavailable instead of errored. A configurable run of consecutive seconds that are not severely errored clears it, and the errored seconds seen in that run are then counted as available time. Seconds in an open run are held in pending counters until the run completes or breaks, so the visible counters never move backwards. The six saturating counters are read through a simple address/data port with one cycle of latency.

Top module: `uasMonitor`

## Requirements
- R1: After reset all six counters read zero and both ends are available.
- R2: A near-end second is errored when its lost count is non-zero or either defect flag is set. An errored second that is not severely errored, seen while available with no open onset run, adds one to the errored count at its own tick; counters change only on ticks.
- R3: A near-end second is severely errored when lost*20 > expected*3 (loss ratio strictly above 15%) or either defect flag is set; exactly 15% is only errored.
- R4: While available, when consecutive severely errored seconds reach the entry length, the end becomes unavailable, the unavailable count grows by the entry length and the run's errored and severely errored seconds are never counted.
- R5: An onset run broken by a second that is not severely errored commits the run's pending seconds to the errored and severely errored counts at the breaking tick, plus the breaking second if it is errored.
- R6: While unavailable, errored and severely errored counts do not move; when consecutive non-severe seconds reach the exit length the end becomes available and the errored seconds of that run are added to the errored count, none of them to the unavailable count.
- R7: A severely errored second during a clearing run adds the run's seconds so far plus itself to the unavailable count and restarts the clearing run.
- R8: A far-end second is both errored and severely errored when the remote-defect indication is set, and the far-end counters follow R4 to R7 independently of the near end.
- R9: Every counter saturates at its all-ones value instead of wrapping.
- R10: Read address 0..5 returns near errored, near severely errored, near unavailable, far errored, far severely errored, far unavailable on the cycle after the address is presented; addresses 6 and 7 read zero.
- R11: An entry or exit length of zero behaves as a length of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse marking the end of a second; summary inputs valid with it |
| lostCnt | input | LOSS_W | Packets lost in the second |
| expCnt | input | LOSS_W | Packets expected in the second |
| lossDefect | input | 1 | Packet-loss defect active in the second |
| degradeDefect | input | 1 | Degradation defect active in the second |
| farDefectSeen | input | 1 | A packet with the remote-defect flag arrived in the second |
| enterLen | input | RUN_W | Severe-second run that declares unavailability |
| exitLen | input | RUN_W | Non-severe run that clears unavailability |
| rdAddr | input | 3 | Counter select |
| rdData | output | CNT_W | Selected counter, registered |

## Verification
The hardest situations to reach are the run boundaries: an onset run that stops one second short of the entry length, and a clearing run interrupted by a severe second after some errored but non-severe seconds. The stimulus steers there by dialling small entry and exit lengths and feeding exact per-second patterns (loss ratios just at and just above 15%, defect flags, remote-defect flags), then reading all six counters after every tick and comparing against a model of the requirements. Saturation is reached with a narrow counter width and a long unavailable stretch.

// File: rtl/uasMonPkg.sv
package uasMonPkg;
  localparam int unsigned INC_W = 8;
  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned CNT_PER_SIDE = 3;
  localparam int unsigned NUM_CNT = NUM_SIDES * CNT_PER_SIDE;

  typedef struct packed {
    logic [INC_W-1:0] addEs;
    logic [INC_W-1:0] addSes;
    logic [INC_W-1:0] addUas;
  } cntStrobeT;
endpackage

// File: rtl/uasCtrl.sv
module uasCtrl
  import uasMonPkg::*;
#(
  parameter int unsigned RUN_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             secTick,
  input  logic             secEs,
  input  logic             secSes,
  input  logic [RUN_W-1:0] enterLen,
  input  logic [RUN_W-1:0] exitLen,
  output cntStrobeT        strobe,
  output logic             unavailQ
);
  logic [RUN_W-1:0] effEnter, effExit, runInc;
  logic [RUN_W-1:0] runQ, runD, pendEsQ, pendEsD, pendSesQ, pendSesD;
  logic             unavailD;

  assign effEnter = (enterLen == '0) ? RUN_W'(1) : enterLen;
  assign effExit  = (exitLen == '0) ? RUN_W'(1) : exitLen;
  assign runInc   = runQ + RUN_W'(1);

  always_comb begin
    strobe   = '0;
    unavailD = unavailQ;
    runD     = runQ;
    pendEsD  = pendEsQ;
    pendSesD = pendSesQ;
    if (secTick) begin
      if (!unavailQ) begin
        if (secSes) begin
          if (runInc == effEnter) begin
            unavailD      = 1'b1;
            strobe.addUas = INC_W'(effEnter);
            runD = '0; pendEsD = '0; pendSesD = '0;
          end else begin
            runD     = runInc;
            pendEsD  = pendEsQ + RUN_W'(1);
            pendSesD = pendSesQ + RUN_W'(1);
          end
        end else begin
          strobe.addEs  = INC_W'(pendEsQ) + INC_W'(secEs);
          strobe.addSes = INC_W'(pendSesQ);
          runD = '0; pendEsD = '0; pendSesD = '0;
        end
      end else begin
        if (secSes) begin
          strobe.addUas = INC_W'(runQ) + INC_W'(1);
          runD = '0; pendEsD = '0; pendSesD = '0;
        end else if (runInc == effExit) begin
          unavailD     = 1'b0;
          strobe.addEs = INC_W'(pendEsQ) + INC_W'(secEs);
          runD = '0; pendEsD = '0; pendSesD = '0;
        end else begin
          runD    = runInc;
          pendEsD = pendEsQ + RUN_W'(secEs);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unavailQ <= 1'b0;
      runQ     <= '0;
      pendEsQ  <= '0;
      pendSesQ <= '0;
    end else begin
      unavailQ <= unavailD;
      runQ     <= runD;
      pendEsQ  <= pendEsD;
      pendSesQ <= pendSesD;
    end
  end
endmodule

// File: rtl/uasDatapath.sv
module uasDatapath
  import uasMonPkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned LOSS_W  = 16,
  parameter int unsigned SES_NUM = 3,
  parameter int unsigned SES_DEN = 20,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [LOSS_W-1:0]             lostCnt,
  input  logic [LOSS_W-1:0]             expCnt,
  input  logic                          lossDefect,
  input  logic                          degradeDefect,
  input  logic                          farDefectSeen,
  input  cntStrobeT [NUM_SIDES-1:0]     strobeVec,
  input  logic [ADDR_W-1:0]             rdAddr,
  output logic [NUM_SIDES-1:0]          secEs,
  output logic [NUM_SIDES-1:0]          secSes,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cntVec,
  output logic [CNT_W-1:0]              rdData
);
  localparam int unsigned SCL_W = LOSS_W + 6;
  localparam int unsigned SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;

  logic [SCL_W-1:0] lostScaled, expScaled;
  logic             anyDefect;

  assign anyDefect  = lossDefect | degradeDefect;
  assign lostScaled = SCL_W'(lostCnt) * SCL_W'(SES_DEN);
  assign expScaled  = SCL_W'(expCnt) * SCL_W'(SES_NUM);

  assign secEs[0]  = (lostCnt != '0) | anyDefect;
  assign secSes[0] = (lostScaled > expScaled) | anyDefect;
  assign secEs[1]  = farDefectSeen;
  assign secSes[1] = farDefectSeen;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    localparam int unsigned SIDE = g / CNT_PER_SIDE;
    localparam int unsigned KIND = g % CNT_PER_SIDE;
    logic [INC_W-1:0] inc;
    logic [SUM_W-1:0] sum;
    logic [CNT_W-1:0] cntQ;

    if (KIND == 0) begin : g_es
      assign inc = strobeVec[SIDE].addEs;
    end else if (KIND == 1) begin : g_ses
      assign inc = strobeVec[SIDE].addSes;
    end else begin : g_uas
      assign inc = strobeVec[SIDE].addUas;
    end

    assign sum = SUM_W'(cntQ) + SUM_W'(inc);

    always_ff @(posedge clk) begin
      if (!rstN)                            cntQ <= '0;
      else if (sum > SUM_W'({CNT_W{1'b1}})) cntQ <= '1;
      else                                  cntQ <= sum[CNT_W-1:0];
    end
    assign cntVec[g] = cntQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                           rdData <= '0;
    else if (rdAddr < ADDR_W'(NUM_CNT))  rdData <= cntVec[rdAddr];
    else                                 rdData <= '0;
  end
endmodule

// File: rtl/uasMonitor.sv
module uasMonitor
  import uasMonPkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned LOSS_W = 16,
  parameter int unsigned RUN_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [LOSS_W-1:0] lostCnt,
  input  logic [LOSS_W-1:0] expCnt,
  input  logic              lossDefect,
  input  logic              degradeDefect,
  input  logic              farDefectSeen,
  input  logic [RUN_W-1:0]  enterLen,
  input  logic [RUN_W-1:0]  exitLen,
  input  logic [2:0]        rdAddr,
  output logic [CNT_W-1:0]  rdData
);
  cntStrobeT [NUM_SIDES-1:0]     strobeVec;
  logic [NUM_SIDES-1:0]          secEs, secSes, unavailVec;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVec;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    uasCtrl #(.RUN_W(RUN_W)) u_ctrl (
      .clk(clk), .rstN(rstN), .secTick(secTick),
      .secEs(secEs[s]), .secSes(secSes[s]),
      .enterLen(enterLen), .exitLen(exitLen),
      .strobe(strobeVec[s]), .unavailQ(unavailVec[s])
    );
  end

  uasDatapath #(.CNT_W(CNT_W), .LOSS_W(LOSS_W), .ADDR_W(3)) u_dp (
    .clk(clk), .rstN(rstN), .lostCnt(lostCnt), .expCnt(expCnt),
    .lossDefect(lossDefect), .degradeDefect(degradeDefect),
    .farDefectSeen(farDefectSeen), .strobeVec(strobeVec), .rdAddr(rdAddr),
    .secEs(secEs), .secSes(secSes), .cntVec(cntVec), .rdData(rdData)
  );
endmodule

// File: rtl/uasMonChecker.sv
module uasMonChecker
  import uasMonPkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          secTick,
  input logic [2:0]                    rdAddr,
  input logic [CNT_W-1:0]              rdData,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cntVec,
  input logic [NUM_SIDES-1:0]          unavailVec
);
  p_quiet_between_ticks_r2: assert property (@(posedge clk) disable iff (!rstN)
    !secTick |=> $stable(cntVec));

  p_unused_addr_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr > 3'd5) |=> (rdData == '0));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_mono
    p_no_decrease_r9: assert property (@(posedge clk) disable iff (!rstN)
      secTick |=> (cntVec[i] >= $past(cntVec[i])));
  end

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_frz
    p_frozen_while_unavail_r6: assert property (@(posedge clk) disable iff (!rstN)
      (secTick && unavailVec[s]) |=> (!unavailVec[s] ||
        ($stable(cntVec[s*CNT_PER_SIDE]) && $stable(cntVec[s*CNT_PER_SIDE+1]))));
  end
endmodule

bind uasMonitor uasMonChecker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .secTick(secTick), .rdAddr(rdAddr), .rdData(rdData),
  .cntVec(cntVec), .unavailVec(unavailVec)
);

// File: tb/tb_uasMonitor.sv
module tb_uasMonitor;
  localparam int CW = 6;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 0, rstN = 0, secTick = 0;
  logic [15:0] lostCnt = 0, expCnt = 0;
  logic lossDefect = 0, degradeDefect = 0, farDefectSeen = 0;
  logic [4:0] enterLen = 5'd4, exitLen = 5'd4;
  logic [2:0] rdAddr = 0;
  logic [CW-1:0] rdData;
  logic rdPend = 0;

  uasMonitor #(.CNT_W(CW), .LOSS_W(16), .RUN_W(5)) dut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .lostCnt(lostCnt), .expCnt(expCnt),
    .lossDefect(lossDefect), .degradeDefect(degradeDefect), .farDefectSeen(farDefectSeen),
    .enterLen(enterLen), .exitLen(exitLen), .rdAddr(rdAddr), .rdData(rdData));

  always #10 clk = ~clk;

  typedef struct { int addr; int exp; string req; } expItemT;
  expItemT expQ[$];
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // requirement model state
  int mCnt[6];
  int mUn[2], mRun[2], mPe[2], mPs[2];
  string curReq = "R1";

  function automatic void addSat(int idx, int v);
    mCnt[idx] = (mCnt[idx] + v > MAXV) ? MAXV : mCnt[idx] + v;
  endfunction

  function automatic void modelSide(int s, bit es, bit ses);
    int effE, effX;
    effE = (enterLen == 0) ? 1 : int'(enterLen);
    effX = (exitLen == 0) ? 1 : int'(exitLen);
    if (mUn[s] == 0) begin
      if (ses) begin
        if (mRun[s] + 1 == effE) begin
          mUn[s] = 1; addSat(s*3+2, effE); mRun[s] = 0; mPe[s] = 0; mPs[s] = 0;
        end else begin
          mRun[s]++; mPe[s]++; mPs[s]++;
        end
      end else begin
        addSat(s*3, mPe[s] + int'(es)); addSat(s*3+1, mPs[s]);
        mRun[s] = 0; mPe[s] = 0; mPs[s] = 0;
      end
    end else begin
      if (ses) begin
        addSat(s*3+2, mRun[s] + 1); mRun[s] = 0; mPe[s] = 0;
      end else if (mRun[s] + 1 == effX) begin
        mUn[s] = 0; addSat(s*3, mPe[s] + int'(es)); mRun[s] = 0; mPe[s] = 0;
      end else begin
        mRun[s]++; mPe[s] += int'(es);
      end
    end
  endfunction

  task automatic readReg(int addr, int exp);
    expItemT it;
    @(negedge clk);
    rdAddr = addr[2:0];
    rdPend = 1;
    it.addr = addr; it.exp = exp; it.req = curReq;
    expQ.push_back(it);
    @(negedge clk);
    rdPend = 0;
  endtask

  task automatic readAll();
    for (int a = 0; a < 6; a++) readReg(a, mCnt[a]);
  endtask

  task automatic tick(int lost, int exp, bit ld, bit dd, bit rdi);
    bit nEs, nSes;
    @(negedge clk);
    lostCnt = lost[15:0]; expCnt = exp[15:0];
    lossDefect = ld; degradeDefect = dd; farDefectSeen = rdi;
    secTick = 1;
    nEs  = (lost != 0) || ld || dd;
    nSes = (lost * 20 > exp * 3) || ld || dd;
    modelSide(0, nEs, nSes);
    modelSide(1, rdi, rdi);
    @(negedge clk);
    secTick = 0; lossDefect = 0; degradeDefect = 0; farDefectSeen = 0;
    lostCnt = 0; expCnt = 0;
    readAll();
  endtask

  // monitor: compares each registered read against the queue head
  initial begin
    forever begin
      @(posedge clk);
      if (rdPend) begin
        expItemT it;
        @(negedge clk);
        it = expQ.pop_front();
        nChecks++;
        if (int'(rdData) != it.exp) begin
          nFails++;
          $display("FAIL %s addr %0d: actual %0d expected %0d", it.req, it.addr, rdData, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) mCnt[i] = 0;
    for (int i = 0; i < 2; i++) begin mUn[i] = 0; mRun[i] = 0; mPe[i] = 0; mPs[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    curReq = "R1"; readAll();
    curReq = "R2"; tick(1, 100, 0, 0, 0); tick(0, 100, 0, 0, 0);
    curReq = "R3"; tick(15, 100, 0, 0, 0); tick(16, 100, 0, 0, 0); tick(0, 100, 0, 0, 0);
    tick(0, 0, 0, 0, 0);
    curReq = "R5"; tick(0, 10, 1, 0, 0); tick(0, 10, 0, 1, 0); tick(50, 100, 0, 0, 0);
    tick(2, 100, 0, 0, 0);
    curReq = "R4"; for (int i = 0; i < 4; i++) tick(0, 100, 0, 1, 0);
    curReq = "R6"; tick(1, 100, 0, 0, 0); tick(0, 100, 0, 0, 0); tick(3, 100, 0, 0, 0);
    tick(0, 100, 0, 0, 0);
    curReq = "R4"; for (int i = 0; i < 4; i++) tick(0, 100, 1, 0, 0);
    curReq = "R7"; tick(1, 100, 0, 0, 0); tick(0, 100, 0, 0, 0); tick(0, 100, 1, 0, 0);
    for (int i = 0; i < 4; i++) tick(0, 100, 0, 0, 0);
    curReq = "R8"; tick(0, 100, 0, 0, 1); tick(0, 100, 0, 0, 0);
    for (int i = 0; i < 4; i++) tick(0, 100, 0, 0, 1);
    tick(0, 100, 0, 0, 0); tick(0, 100, 0, 0, 1);
    for (int i = 0; i < 4; i++) tick(0, 100, 0, 0, 0);
    curReq = "R10"; readReg(6, 0); readReg(7, 0);
    curReq = "R11"; enterLen = 0; exitLen = 0;
    tick(0, 100, 1, 0, 1); tick(1, 100, 0, 0, 0); tick(0, 100, 0, 0, 0);
    curReq = "R9"; enterLen = 1; exitLen = 31;
    for (int i = 0; i < 70; i++) tick(0, 100, 0, 1, 1);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule